// File: doc/BRIEF.md
# Programmable Gain, Offset and Clamp Output Datapath

This block turns a signed, already filtered sensor sample into an unsigned 14-bit code for an output DAC. It runs three registered steps in a fixed order. First the sample is scaled by a programmable gain. Then a programmable quiescent offset is added and the sum is saturated to the code range. Last, the result is limited between a programmable low clamp and a programmable high clamp. Once the part is locked, a supply fault overrides the clamps and forces the code to full scale. A readback register keeps a copy of the last code that was delivered.

The gain is held in sign-magnitude and the offset in two's complement. Both are scaled to supply-relative units. The two clamp registers have different widths and are converted to code units by different scale factors.

Samples travel on a valid/ready stream, and the output code leaves on a valid/ready stream. Back-pressure works as follows:
- A stage moves forward when the stage after it is empty or is being emptied in the same cycle.
- When `out_ready` stays low, the pipeline fills up to three samples and `in_ready` then drops.
- A presented output holds its code until it is taken.

Each configuration input is sampled at the stage that uses it:
- The gain is sampled when a sample is accepted.
- The offset is sampled one stage later.
- The clamps, the lock status and the fault flags are sampled as the result enters the last stage.

Configuration is expected to stay stable while samples are in flight.

Top module: `sense_gain_clamp`

## Requirements
- R1: The gain register is 14 bits in sign-magnitude: bit 13 is the sign (1 = negative) and bits 12:0 are the magnitude, in units of 1/2048. The scaled value is floor(sample × signed gain / 2048). A negative zero acts exactly like zero.
- R2: The offset register is 11-bit two's complement (−1024..1023). It is added after the multiply with a weight of 16 code steps per LSB, so that 512 yields mid-scale 8192 for a zero sample.
- R3: Before clamping, the sum of the scaled sample and the offset is saturated to 0..16383.
- R4: The low clamp register is 8 bits, and its code is floor(reg × 8192 / 255). A saturated sum below this code is replaced by it.
- R5: The high clamp register is 9 bits, and its code is floor(reg × 16383 / 511). A value above this code is replaced by it. The high clamp is applied after the low clamp, so it wins when the two cross.
- R6: The code is forced to 16383 when `locked` is high and either `uv_flag` or `ov_flag` is high. While `locked` is low, both fault flags have no effect on the code.
- R7: With `out_ready` held high, a sample accepted at one clock edge appears with `out_valid` three edges later. One sample is accepted every cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_code` hold. The pipeline absorbs exactly three samples before `in_ready` falls. No sample is lost or duplicated.
- R9: `readback` takes the delivered code at every output handshake and holds it until the next one.
- R10: After reset, `out_valid` is low, `in_ready` is high and `readback` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Sample can be accepted |
| in_sample | input | 14 | Signed filtered sample |
| gain_reg | input | 14 | Gain, sign-magnitude |
| offset_reg | input | 11 | Quiescent offset, two's complement |
| clamp_lo_reg | input | 8 | Low clamp setting |
| clamp_hi_reg | input | 9 | High clamp setting |
| locked | input | 1 | Part is locked; enables fault override |
| uv_flag | input | 1 | Supply below undervoltage level |
| ov_flag | input | 1 | Supply above overvoltage level |
| out_valid | output | 1 | Output code present |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | 14 | Code to the DAC |
| readback | output | 14 | Last delivered code |

## Verification
Eight gain settings are each swept over the sample range with four offsets. The gain settings are zero, negative zero, ±1, ±full scale and two odd values. This separates sign handling, floor rounding of negative products and offset sign extension. The extreme offsets drive the sum into both saturation limits.

A grid of low and high clamp settings, including crossed pairs, separates the two scale factors and shows which clamp takes priority. All eight combinations of lock and the two fault flags show that the override applies only when the part is locked.

Random and fully stalled `out_ready` patterns confirm that order and count survive back-pressure.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int SAMPLE_W_DEF  = 14;
  localparam int GAIN_W_DEF    = 14;
  localparam int GAIN_FRAC_DEF = 11;
  localparam int OFF_W_DEF     = 11;
  localparam int LO_W_DEF      = 8;
  localparam int HI_W_DEF      = 9;
  localparam int CODE_W_DEF    = 14;

  // ready of a register stage: room now, or room made this cycle
  function automatic logic stage_ready(input logic full, input logic dn_ready);
    return dn_ready || !full;
  endfunction
endpackage

// File: rtl/sgc_mul.sv
module sgc_mul #(
  parameter int SAMPLE_W  = 14,
  parameter int GAIN_W    = 14,
  parameter int GAIN_FRAC = 11
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         up_valid,
  output logic                                         up_ready,
  input  logic signed [SAMPLE_W-1:0]                   sample,
  input  logic        [GAIN_W-1:0]                     gain,
  output logic                                         dn_valid,
  input  logic                                         dn_ready,
  output logic signed [SAMPLE_W+GAIN_W-GAIN_FRAC-1:0]  scaled
);
  localparam int PW    = SAMPLE_W + GAIN_W;
  localparam int SCL_W = SAMPLE_W + GAIN_W - GAIN_FRAC;

  logic signed [GAIN_W-1:0] mag_s;
  logic signed [PW-1:0]     prod;
  logic signed [PW-1:0]     prod_sgn;

  assign mag_s    = {1'b0, gain[GAIN_W-2:0]};
  assign prod     = PW'(sample) * PW'(mag_s);
  assign prod_sgn = gain[GAIN_W-1] ? -prod : prod;
  assign up_ready = sgc_pkg::stage_ready(dn_valid, dn_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      scaled   <= '0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (up_valid && up_ready) scaled <= SCL_W'(prod_sgn >>> GAIN_FRAC);
    end
  end
endmodule

// File: rtl/sgc_add.sv
module sgc_add #(
  parameter int SCL_W  = 17,
  parameter int OFF_W  = 11,
  parameter int CODE_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up_valid,
  output logic                    up_ready,
  input  logic signed [SCL_W-1:0] scaled,
  input  logic        [OFF_W-1:0] offset,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic        [CODE_W-1:0] code
);
  localparam int SUM_W     = SCL_W + 2;
  localparam int OFF_SHIFT = CODE_W - OFF_W + 1;

  logic signed [SUM_W-1:0] scl_ext;
  logic signed [SUM_W-1:0] off_ext;
  logic signed [SUM_W-1:0] sum;
  logic        [CODE_W-1:0] sat;

  assign scl_ext  = {{2{scaled[SCL_W-1]}}, scaled};
  assign off_ext  = {{(SUM_W-OFF_W){offset[OFF_W-1]}}, offset} <<< OFF_SHIFT;
  assign sum      = scl_ext + off_ext;
  assign up_ready = sgc_pkg::stage_ready(dn_valid, dn_ready);

  always_comb begin
    if (sum[SUM_W-1])                 sat = '0;
    else if (|sum[SUM_W-2:CODE_W])    sat = '1;
    else                              sat = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      code     <= '0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (up_valid && up_ready) code <= sat;
    end
  end
endmodule

// File: rtl/sgc_clamp.sv
module sgc_clamp #(
  parameter int CODE_W = 14,
  parameter int LO_W   = 8,
  parameter int HI_W   = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [CODE_W-1:0] code_in,
  input  logic [LO_W-1:0]   lo_reg,
  input  logic [HI_W-1:0]   hi_reg,
  input  logic              locked,
  input  logic              uv_flag,
  input  logic              ov_flag,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [CODE_W-1:0] code_out
);
  localparam int LO_FS  = 1 << (CODE_W - 1);
  localparam int LO_DEN = (1 << LO_W) - 1;
  localparam int HI_FS  = (1 << CODE_W) - 1;
  localparam int HI_DEN = (1 << HI_W) - 1;

  logic [CODE_W-1:0] lo_code;
  logic [CODE_W-1:0] hi_code;
  logic [CODE_W-1:0] above_lo;
  logic [CODE_W-1:0] limited;
  logic [CODE_W-1:0] result;
  logic              fault;

  assign lo_code  = CODE_W'((32'(lo_reg) * 32'(LO_FS)) / 32'(LO_DEN));
  assign hi_code  = CODE_W'((32'(hi_reg) * 32'(HI_FS)) / 32'(HI_DEN));
  assign above_lo = (code_in < lo_code) ? lo_code : code_in;
  assign limited  = (above_lo > hi_code) ? hi_code : above_lo;
  assign fault    = locked && (uv_flag || ov_flag);
  assign result   = fault ? '1 : limited;
  assign up_ready = sgc_pkg::stage_ready(dn_valid, dn_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      code_out <= '0;
    end else begin
      if (up_ready) dn_valid <= up_valid;
      if (up_valid && up_ready) code_out <= result;
    end
  end
endmodule

// File: rtl/sense_gain_clamp.sv
module sense_gain_clamp #(
  parameter int SAMPLE_W  = sgc_pkg::SAMPLE_W_DEF,
  parameter int GAIN_W    = sgc_pkg::GAIN_W_DEF,
  parameter int GAIN_FRAC = sgc_pkg::GAIN_FRAC_DEF,
  parameter int OFF_W     = sgc_pkg::OFF_W_DEF,
  parameter int LO_W      = sgc_pkg::LO_W_DEF,
  parameter int HI_W      = sgc_pkg::HI_W_DEF,
  parameter int CODE_W    = sgc_pkg::CODE_W_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [GAIN_W-1:0]   gain_reg,
  input  logic [OFF_W-1:0]    offset_reg,
  input  logic [LO_W-1:0]     clamp_lo_reg,
  input  logic [HI_W-1:0]     clamp_hi_reg,
  input  logic                locked,
  input  logic                uv_flag,
  input  logic                ov_flag,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CODE_W-1:0]   out_code,
  output logic [CODE_W-1:0]   readback
);
  localparam int SCL_W = SAMPLE_W + GAIN_W - GAIN_FRAC;

  logic                    mul_valid, mul_ready;
  logic signed [SCL_W-1:0] mul_scaled;
  logic                    add_valid, add_ready;
  logic [CODE_W-1:0]       add_code;

  sgc_mul #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .up_valid(in_valid), .up_ready(in_ready),
    .sample(in_sample), .gain(gain_reg),
    .dn_valid(mul_valid), .dn_ready(mul_ready), .scaled(mul_scaled)
  );

  sgc_add #(.SCL_W(SCL_W), .OFF_W(OFF_W), .CODE_W(CODE_W)) u_add (
    .clk(clk), .rst_n(rst_n),
    .up_valid(mul_valid), .up_ready(mul_ready),
    .scaled(mul_scaled), .offset(offset_reg),
    .dn_valid(add_valid), .dn_ready(add_ready), .code(add_code)
  );

  sgc_clamp #(.CODE_W(CODE_W), .LO_W(LO_W), .HI_W(HI_W)) u_clamp (
    .clk(clk), .rst_n(rst_n),
    .up_valid(add_valid), .up_ready(add_ready),
    .code_in(add_code), .lo_reg(clamp_lo_reg), .hi_reg(clamp_hi_reg),
    .locked(locked), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .dn_valid(out_valid), .dn_ready(out_ready), .code_out(out_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      readback <= '0;
    else if (out_valid && out_ready) readback <= out_code;
  end
endmodule

// File: rtl/sense_gain_clamp_chk.sv
module sense_gain_clamp_chk #(
  parameter int CODE_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CODE_W-1:0] out_code,
  input logic [CODE_W-1:0] readback,
  input logic              locked,
  input logic              uv_flag,
  input logic              ov_flag
);
  // R8: a stalled output holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_code));

  // R7: a fresh output follows an acceptance three edges earlier
  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready, 3));

  // R6: a result loaded while locked with a fault is full scale
  p_fault_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(locked && (uv_flag || ov_flag) && (!out_valid || out_ready))
    |-> out_code == {CODE_W{1'b1}});

  // R9: readback captures the delivered code
  p_readback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> readback == $past(out_code));
endmodule

bind sense_gain_clamp sense_gain_clamp_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
  .readback(readback), .locked(locked), .uv_flag(uv_flag), .ov_flag(ov_flag)
);

// File: tb/sense_gain_clamp_tb.sv
`timescale 1ns/1ps
module sense_gain_clamp_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [13:0] in_sample = '0;
  logic [13:0] gain_reg = '0;
  logic [10:0] offset_reg = '0;
  logic [7:0]  clamp_lo_reg = '0;
  logic [8:0]  clamp_hi_reg = '0;
  logic        locked = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [13:0] out_code;
  logic [13:0] readback;

  int     n_checks = 0;
  int     n_fail = 0;
  int     q[$];
  string  cur_tag = "R10";
  logic [15:0] lfsr = 16'hACE1;
  bit     rb_pend = 0;
  int     rb_exp = 0;

  always #2.5 clk = ~clk;

  sense_gain_clamp u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .gain_reg(gain_reg), .offset_reg(offset_reg),
    .clamp_lo_reg(clamp_lo_reg), .clamp_hi_reg(clamp_hi_reg),
    .locked(locked), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .out_valid(out_valid), .out_ready(out_ready), .out_code(out_code),
    .readback(readback)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int s);
    longint p;
    int mag, o, sum, loc, hic;
    mag = int'(gain_reg[12:0]);
    p = longint'(s) * longint'(mag);
    if (gain_reg[13]) p = -p;
    p = p >>> 11;
    o = int'(offset_reg);
    if (o >= 1024) o -= 2048;
    sum = int'(p) + o * 16;
    if (sum < 0) sum = 0;
    if (sum > 16383) sum = 16383;
    loc = int'(clamp_lo_reg) * 8192 / 255;
    hic = int'(clamp_hi_reg) * 16383 / 511;
    if (sum < loc) sum = loc;
    if (sum > hic) sum = hic;
    if (locked && (uv_flag || ov_flag)) sum = 16383;
    return sum;
  endfunction

  // mode 0: ready high, 1: pseudo-random ready, 2: ready low
  task automatic cycle(input bit iv, input int s, input int mode, output bit took);
    @(negedge clk);
    if (rb_pend) begin
      chk(int'(readback) == rb_exp, "R9", int'(readback), rb_exp);
      rb_pend = 0;
    end
    in_valid  = iv;
    in_sample = 14'(s);
    out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? lfsr[0] : 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    #1;
    if (out_valid && out_ready) begin
      if (q.size() == 0) chk(0, "R8 unexpected output", int'(out_code), -1);
      else begin
        chk(int'(out_code) == q[0], cur_tag, int'(out_code), q[0]);
        void'(q.pop_front());
      end
      rb_exp = int'(out_code);
      rb_pend = 1;
    end
    took = iv && in_ready;
    if (took) q.push_back(exp_code(s));
  endtask

  task automatic drain();
    bit t;
    for (int g = 0; g < 40 && q.size() > 0; g++) cycle(0, 0, 0, t);
    chk(q.size() == 0, "R8 samples lost", q.size(), 0);
    q.delete();
  endtask

  task automatic run(input int s0, input int step, input int n, input int mode);
    bit t;
    for (int i = 0; i < n; i++) begin
      t = 0;
      for (int a = 0; a < 200 && !t; a++) cycle(1, s0 + i * step, mode, t);
    end
    drain();
  endtask

  initial begin
    #(5ns * 190000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [13:0] gains [8];
    logic [10:0] offs [4];
    bit t;
    int acc, held, lat;
    gains = '{14'h0000, 14'h2000, 14'd2048, 14'h2800, 14'h1FFF, 14'h3FFF, 14'd1000, 14'h2BB8};
    offs  = '{11'd0, 11'd512, 11'h400, 11'd1023};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
    chk(readback == 14'd0, "R10 readback", int'(readback), 0);

    // R1 R2 R3: gain and offset sweep, clamps wide open
    clamp_lo_reg = 8'd0;
    clamp_hi_reg = 9'd511;
    cur_tag = "R1 R2 R3 R8";
    foreach (gains[gi]) begin
      foreach (offs[oi]) begin
        gain_reg = gains[gi];
        offset_reg = offs[oi];
        run(-8192, 37, 443, gi % 2);
      end
    end

    // R4 R5: clamp grid with unity gain and mid-scale offset
    gain_reg = 14'd2048;
    offset_reg = 11'd512;
    cur_tag = "R4 R5";
    for (int lo = 0; lo < 256; lo += 17) begin
      for (int hi = 0; hi < 512; hi += 73) begin
        clamp_lo_reg = 8'(lo);
        clamp_hi_reg = 9'(hi);
        run(-8192, 257, 64, (lo / 17) % 2);
      end
    end

    // R6: every lock and fault combination
    clamp_lo_reg = 8'd0;
    clamp_hi_reg = 9'd255;
    cur_tag = "R6";
    for (int c = 0; c < 8; c++) begin
      locked  = c[0];
      uv_flag = c[1];
      ov_flag = c[2];
      run(-8000, 4000, 5, 0);
    end
    locked = 0; uv_flag = 0; ov_flag = 0;

    // R7: latency of a single sample
    clamp_hi_reg = 9'd511;
    cur_tag = "R7";
    @(negedge clk);
    in_valid = 1; in_sample = 14'd100; out_ready = 1;
    #1;
    chk(in_ready == 1'b1, "R7 accept", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 3, "R7 latency", lat, 3);
    chk(int'(out_code) == exp_code(100), "R7 value", int'(out_code), exp_code(100));
    @(negedge clk);
    rb_pend = 0;

    // R7: one sample per cycle with ready high
    acc = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1, i * 300 - 3000, 0, t);
      acc += int'(t);
    end
    chk(acc == 20, "R7 throughput", acc, 20);
    drain();

    // R8: full stall absorbs three samples and holds the code
    cur_tag = "R8";
    acc = 0;
    held = -1;
    for (int i = 0; i < 8; i++) begin
      cycle(1, i * 500, 2, t);
      acc += int'(t);
      if (out_valid) begin
        if (held < 0) held = int'(out_code);
        else chk(int'(out_code) == held, "R8 hold", int'(out_code), held);
      end
    end
    chk(acc == 3, "R8 depth", acc, 3);
    chk(in_ready == 1'b0, "R8 in_ready low", int'(in_ready), 0);
    drain();
    @(negedge clk);
    if (rb_pend) chk(int'(readback) == rb_exp, "R9", int'(readback), rb_exp);
    rb_pend = 0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule